// File: doc/BRIEF.md
# Voice Group Playlist Sequencer

This block turns a group number into an ordered series of memory-block requests for a sample engine. Each voice group is a list of entries kept in one shared entry pool, and each entry names one of the voice memory blocks. A group record holds the pool index of its first entry and its number of entries. Several groups may point into overlapping parts of the pool, and one list may name the same block more than once, including twice in a row. A long message can therefore be built from short reusable pieces.

A start request with a group number is taken only while the block is idle. The block then reads the group record and fetches the entries one after another. For each entry it places the block number on its output with a one-cycle strobe. It then waits for the sample engine to report that block as finished. After the last entry it gives a one-cycle end-of-group pulse. An abort drops the block back to idle at once, and the group then ends silently. The group records and the pool entries are loaded through a single write port, which selects one of the two memories.

Top module: `vgrp_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `blk_start` and `group_end` are low and `blk_num` is 0.
- R2: A write with `cfg_sel`=0 stores the record of group `cfg_addr`: bits 19:10 hold the first pool index and bits 9:0 hold the entry count. A write with `cfg_sel`=1 stores `cfg_wdata[7:0]` as pool entry `cfg_addr`. A record write with `cfg_addr` at or above 30 changes no group.
- R3: Suppose `start` is high in cycle c while the block is idle and `start_group` is below 30. Then `busy` is high from cycle c+1. If the group's count is nonzero, `blk_start` is high in cycle c+3 and `blk_num` equals the pool entry at the first index.
- R4: Entries are issued strictly in list order, and the pool index advances by one per entry. Each `blk_start` pulse lasts one cycle. After a `blk_done` high in cycle d that is not the last entry's, the next pulse comes in cycle d+2. `blk_num` changes only in cycles where `blk_start` is high.
- R5: A block named several times in a list, back to back or apart, is issued once for each time it is named. Different groups that name the same pool entries issue the same block numbers.
- R6: If `blk_done` is high in cycle d for the last entry, then in cycle d+1 `group_end` is high for one cycle and `busy` is low.
- R7: If a group has count 0 and is started in cycle c, `busy` is high only in cycle c+1 and `group_end` is high in cycle c+2. No `blk_start` is issued.
- R8: If `abort` is high in cycle a, then in cycle a+1 `busy`, `blk_start` and `group_end` are all low, and the block stays idle after that. Abort wins over a `start` or a final `blk_done` in the same cycle.
- R9: `start` is ignored while `busy` is high, and it is ignored when `start_group` is 30 or above.
- R10: `blk_done` has no effect unless the block is waiting for the current entry to finish.
- R11: The pool index wraps from 895 to 0 when a list runs past the end of the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects the group records, 1 selects the entry pool |
| cfg_addr | input | 10 | Group number or pool index to write |
| cfg_wdata | input | 20 | Record {first index, count} or block number in bits 7:0 |
| start | input | 1 | Request to play a group |
| start_group | input | 5 | Group to play |
| abort | input | 1 | Stop playback at once, with no end pulse |
| blk_done | input | 1 | Sample engine has finished the current block |
| blk_num | output | 8 | Block number of the current entry |
| blk_start | output | 1 | One-cycle strobe: fetch `blk_num` |
| busy | output | 1 | A group is in progress |
| group_end | output | 1 | One-cycle pulse after the last entry finishes |

## Verification
An abort can land in the same cycle as the `blk_done` of a group's last entry. In that case the block must end with no `group_end` pulse. An abort can also arrive together with a `start` while the block is idle, and then no playback may begin. The random runs pick the entry at which to abort and whether `blk_done` rises with it, and some of those picks hit the last entry. The bench then checks that `busy`, `blk_start` and `group_end` are all low in the next two cycles. A start request during playback and done strobes during the lookup cycles are also mixed in. The bench confirms that the issued block sequence still matches the list held in its own model.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_ISSUE,
    ST_WAIT
  } seq_state_t;

endpackage

// File: rtl/vgrp_ram.sv
module vgrp_ram #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 896,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/vgrp_ctrl.sv
module vgrp_ctrl
  import vgrp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 30,
  parameter int unsigned POOL_DEPTH = 896,
  parameter int unsigned GRP_W      = 5,
  parameter int unsigned BLK_W      = 8,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned CNT_W      = 10,
  localparam int unsigned POOL_AW   = $clog2(POOL_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [GRP_W-1:0]   start_group,
  input  logic               abort,
  input  logic               blk_done,
  input  logic [IDX_W-1:0]   rec_first,
  input  logic [CNT_W-1:0]   rec_count,
  input  logic [BLK_W-1:0]   ent_q,
  output logic [POOL_AW-1:0] ent_raddr,
  output logic [BLK_W-1:0]   blk_num,
  output logic               blk_start,
  output logic               busy,
  output logic               group_end
);

  seq_state_t         state;
  logic [POOL_AW-1:0] ptr;
  logic [POOL_AW-1:0] ptr_inc;
  logic [CNT_W-1:0]   remain;
  logic               grp_ok;

  assign grp_ok    = 32'(start_group) < NUM_GROUPS;
  assign ent_raddr = (state == ST_LOOK) ? rec_first[POOL_AW-1:0] : ptr;

  generate
    if ((1 << POOL_AW) == POOL_DEPTH) begin : g_pow2
      assign ptr_inc = ent_raddr + 1'b1;
    end else begin : g_wrap
      assign ptr_inc = (ent_raddr == POOL_AW'(POOL_DEPTH - 1)) ? '0 : ent_raddr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      remain    <= '0;
      blk_num   <= '0;
      blk_start <= 1'b0;
      busy      <= 1'b0;
      group_end <= 1'b0;
    end else begin
      blk_start <= 1'b0;
      group_end <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start && grp_ok) begin
              state <= ST_LOOK;
              busy  <= 1'b1;
            end
          end
          ST_LOOK: begin
            if (rec_count == '0) begin
              group_end <= 1'b1;
              busy      <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              remain <= rec_count;
              ptr    <= ptr_inc;
              state  <= ST_ISSUE;
            end
          end
          ST_ISSUE: begin
            blk_num   <= ent_q;
            blk_start <= 1'b1;
            state     <= ST_WAIT;
          end
          ST_WAIT: begin
            if (blk_done) begin
              if (remain == CNT_W'(1)) begin
                group_end <= 1'b1;
                busy      <= 1'b0;
                state     <= ST_IDLE;
              end else begin
                remain <= remain - 1'b1;
                ptr    <= ptr_inc;
                state  <= ST_ISSUE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/vgrp_seq.sv
module vgrp_seq #(
  parameter int unsigned NUM_GROUPS = 30,
  parameter int unsigned NUM_BLOCKS = 254,
  parameter int unsigned POOL_DEPTH = 896,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned CNT_W      = 10,
  localparam int unsigned GRP_W     = $clog2(NUM_GROUPS),
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS),
  localparam int unsigned POOL_AW   = $clog2(POOL_DEPTH),
  localparam int unsigned REC_W     = IDX_W + CNT_W,
  localparam int unsigned CFG_AW    = (GRP_W > POOL_AW) ? GRP_W : POOL_AW,
  localparam int unsigned CFG_DW    = (REC_W > BLK_W) ? REC_W : BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              start,
  input  logic [GRP_W-1:0]  start_group,
  input  logic              abort,
  input  logic              blk_done,
  output logic [BLK_W-1:0]  blk_num,
  output logic              blk_start,
  output logic              busy,
  output logic              group_end
);

  logic               tbl_we;
  logic               pool_we;
  logic [REC_W-1:0]   tbl_q;
  logic [BLK_W-1:0]   ent_q;
  logic [POOL_AW-1:0] ent_raddr;

  assign tbl_we  = cfg_we && !cfg_sel && (32'(cfg_addr) < NUM_GROUPS);
  assign pool_we = cfg_we &&  cfg_sel && (32'(cfg_addr) < POOL_DEPTH);

  vgrp_ram #(.WIDTH(REC_W), .DEPTH(NUM_GROUPS)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (cfg_addr[GRP_W-1:0]),
    .wdata (cfg_wdata[REC_W-1:0]),
    .raddr (start_group),
    .rdata (tbl_q)
  );

  vgrp_ram #(.WIDTH(BLK_W), .DEPTH(POOL_DEPTH)) u_pool (
    .clk   (clk),
    .we    (pool_we),
    .waddr (cfg_addr[POOL_AW-1:0]),
    .wdata (cfg_wdata[BLK_W-1:0]),
    .raddr (ent_raddr),
    .rdata (ent_q)
  );

  vgrp_ctrl #(
    .NUM_GROUPS (NUM_GROUPS),
    .POOL_DEPTH (POOL_DEPTH),
    .GRP_W      (GRP_W),
    .BLK_W      (BLK_W),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_group (start_group),
    .abort       (abort),
    .blk_done    (blk_done),
    .rec_first   (tbl_q[REC_W-1:CNT_W]),
    .rec_count   (tbl_q[CNT_W-1:0]),
    .ent_q       (ent_q),
    .ent_raddr   (ent_raddr),
    .blk_num     (blk_num),
    .blk_start   (blk_start),
    .busy        (busy),
    .group_end   (group_end)
  );

endmodule

// File: rtl/vgrp_seq_chk.sv
module vgrp_seq_chk #(
  parameter int unsigned NUM_GROUPS = 30,
  parameter int unsigned GRP_W      = 5,
  parameter int unsigned BLK_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [GRP_W-1:0] start_group,
  input logic             abort,
  input logic [BLK_W-1:0] blk_num,
  input logic             blk_start,
  input logic             busy,
  input logic             group_end
);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> !blk_start);

  a_r4_num_holds: assert property (@(posedge clk) disable iff (rst)
    !blk_start |-> $stable(blk_num));

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !blk_start && !group_end));

  a_r6_end_not_busy: assert property (@(posedge clk) disable iff (rst)
    group_end |-> !busy);

  a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && !$past(abort) && ($past(32'(start_group)) < NUM_GROUPS)));

  a_r4_strobe_inside_busy: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> busy);

endmodule

bind vgrp_seq vgrp_seq_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GRP_W      (GRP_W),
  .BLK_W      (BLK_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .start_group (start_group),
  .abort       (abort),
  .blk_num     (blk_num),
  .blk_start   (blk_start),
  .busy        (busy),
  .group_end   (group_end)
);

// File: tb/sim_vgrp_seq.sv
`timescale 1ns/1ps
module sim_vgrp_seq;

  localparam int NG = 30;
  localparam int PD = 896;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [4:0]  start_group = '0;
  logic        abort = 1'b0;
  logic        blk_done = 1'b0;
  logic [7:0]  blk_num;
  logic        blk_start;
  logic        busy;
  logic        group_end;

  int vecs = 0;
  int bad = 0;
  bit finished = 1'b0;

  int first_m [NG];
  int cnt_m   [NG];
  int pool_m  [PD];

  always #10 clk = ~clk;

  vgrp_seq u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .start_group(start_group), .abort(abort),
    .blk_done(blk_done), .blk_num(blk_num), .blk_start(blk_start), .busy(busy),
    .group_end(group_end)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(req, busy, 0);
    chk(req, blk_start, 0);
    chk(req, group_end, 0);
  endtask

  task automatic wr_tbl(input int g, input int first, input int cnt);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 10'(g);
    cfg_wdata = {10'(first), 10'(cnt)};
    @(negedge clk);
    cfg_we = 1'b0;
    if (g < NG) begin
      first_m[g] = first;
      cnt_m[g] = cnt;
    end
  endtask

  // Play group g; abort_k >= 0 aborts while waiting on that entry.
  task automatic run_group(input int g, input int abort_k, input bit abort_done,
                           input bit noise, input bit restart);
    int n;
    int idx;
    int held;
    n = cnt_m[g];
    idx = first_m[g];
    start = 1'b1; start_group = 5'(g); blk_done = noise;
    @(negedge clk);
    start = 1'b0;
    chk("R3 busy after start", busy, 1);
    chk("R3 no early strobe", blk_start, 0);
    @(negedge clk);
    if (n == 0) begin
      blk_done = 1'b0;
      chk("R7 empty group end", group_end, 1);
      chk("R7 empty group busy", busy, 0);
      chk("R7 empty group strobe", blk_start, 0);
      @(negedge clk);
      idle_chk("R7 empty group after");
      return;
    end
    chk("R10 lookup ignores done", blk_start, 0);
    chk("R10 lookup busy", busy, 1);
    @(negedge clk);
    blk_done = 1'b0;
    chk("R3 first strobe", blk_start, 1);
    chk("R3 first block", blk_num, pool_m[idx]);
    for (int k = 0; k < n; k++) begin
      held = blk_num;
      for (int j = 0; j < int'($urandom % 3); j++) begin
        start = restart && (j == 0);
        start_group = 5'((g + 1) % NG);
        @(negedge clk);
        start = 1'b0;
        chk("R9 restart ignored busy", busy, 1);
        chk("R4 single strobe", blk_start, 0);
        chk("R4 block held", blk_num, held);
      end
      if (k == abort_k) begin
        abort = 1'b1; blk_done = abort_done;
        @(negedge clk);
        abort = 1'b0; blk_done = 1'b0;
        idle_chk("R8 abort");
        @(negedge clk);
        idle_chk("R8 abort stays idle");
        return;
      end
      blk_done = 1'b1;
      @(negedge clk);
      blk_done = 1'b0;
      if (k == n - 1) begin
        chk("R6 end pulse", group_end, 1);
        chk("R6 busy low", busy, 0);
        @(negedge clk);
        chk("R6 end single", group_end, 0);
        chk("R6 stays idle", busy, 0);
      end else begin
        idx = (idx + 1) % PD;
        chk("R4 gap cycle", blk_start, 0);
        @(negedge clk);
        chk("R4 next strobe", blk_start, 1);
        chk("R4 next block order", blk_num, pool_m[idx]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    @(negedge clk);
    rst = 1'b0;
    idle_chk("R1 after reset");
    chk("R1 reset blk_num", blk_num, 0);

    // Fill the pool (R2): random blocks, plus directed entries.
    for (int i = 0; i < PD; i++) pool_m[i] = int'($urandom % 254);
    pool_m[0] = 5; pool_m[1] = 5; pool_m[2] = 9;
    pool_m[894] = 17; pool_m[895] = 33;
    cfg_we = 1'b1; cfg_sel = 1'b1;
    for (int i = 0; i < PD; i++) begin
      cfg_addr = 10'(i); cfg_wdata = 20'(pool_m[i]);
      @(negedge clk);
    end
    cfg_we = 1'b0;

    wr_tbl(0, 0, 3);     // R5 back-to-back repeat
    wr_tbl(1, 1, 2);     // R5 shared with group 0
    wr_tbl(2, 300, 0);   // R7 empty
    wr_tbl(3, 894, 4);   // R11 wrap
    for (int g = 4; g < NG; g++) wr_tbl(g, int'($urandom % PD), int'($urandom % 6));

    run_group(0, -1, 0, 0, 0);   // R5
    run_group(1, -1, 0, 0, 0);   // R5 shared
    run_group(2, -1, 0, 0, 0);   // R7
    run_group(3, -1, 0, 0, 0);   // R11
    run_group(0, -1, 0, 1, 1);   // R9 R10

    // R2: out-of-range record write must not alias group 0.
    wr_tbl(32, 5, 1);
    run_group(0, -1, 0, 0, 0);

    // R9: invalid group numbers are ignored.
    for (int v = 30; v < 32; v++) begin
      start = 1'b1; start_group = 5'(v);
      @(negedge clk);
      start = 1'b0;
      idle_chk("R9 invalid group");
      @(negedge clk);
      idle_chk("R9 invalid group later");
    end

    // R10: stray done while idle.
    blk_done = 1'b1;
    @(negedge clk);
    blk_done = 1'b0;
    idle_chk("R10 idle done");

    // R8: abort with start while idle.
    start = 1'b1; abort = 1'b1; start_group = 5'd0;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    idle_chk("R8 abort beats start");
    @(negedge clk);
    idle_chk("R8 abort beats start later");

    // R8: abort together with the last done.
    run_group(0, 2, 1, 0, 0);
    run_group(3, 0, 0, 0, 0);

    for (int r = 0; r < 80; r++) begin
      int g;
      int ak;
      g = int'($urandom % NG);
      ak = -1;
      if (cnt_m[g] > 0 && ($urandom % 4) == 0) ak = int'($urandom % cnt_m[g]);
      run_group(g, ak, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R4 watchdog expired act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule